// File: doc/BRIEF.md
# Configurable Fibonacci LFSR Generator

A 16-bit many-to-one linear feedback shift register that emits a pseudorandom serial bit stream and exposes its whole state. Each enabled step moves every bit one place toward bit 0. The parity of the tapped bits, or its complement when XNOR feedback is selected, enters the top bit. The tap set comes from a runtime mask in which bit i selects register bit i. An optional mirror mapping turns a tap set into its reciprocal, which is also maximal-length.

A seed can be loaded at any time. A flag shows when the register holds the one state that can never change under the selected feedback. A period counter counts the steps taken since the last seed load. When the loaded seed first appears again, the counter latches the step count and gives a one-cycle done pulse. This lets a tap set be qualified in hardware.

Top module: `lfsr_fib_gen`

## Requirements
- R1: On a step, new state[14:0] equals old state[15:1] and the feedback bit enters state[15]. `bit_o` always equals `state_o[0]`.
- R2: With XOR feedback (`xnor_mode_i`=0) and tap mask 0x002D (taps 16,14,13,11, meaning feedback is the parity of bits 0,2,3,5), state 0xACE1 steps to 0x5670.
- R3: With mask 0x002D and XOR feedback, a seed of 0xACE1 recurs after exactly 65535 steps, and the state is never 0x0000 on the way.
- R4: With `xnor_mode_i`=1, the feedback is the complement of the tap parity. The reset state 0x0000 then steps to 0x8000 and on through valid states. 0xFFFF never changes.
- R5: With XOR feedback, state 0x0000 stays 0x0000 on every step.
- R6: `load_i` has priority over `step_i`. After a load edge, the state equals `seed_i`.
- R7: With `step_i` and `load_i` both low, the state holds.
- R8: When `mirror_i`=1, the effective mask keeps bit 0 and moves mask bit k to bit 16-k for k=1..15. Mask 0x100B (taps 16,15,13,4), mirrored, recurs a seed after 65535 steps.
- R9: `lockup_o` is combinational. It is 1 exactly when the state is 0x0000 in XOR mode or 0xFFFF in XNOR mode.
- R10: After a load, every step increments a 17-bit counter. On the step that first brings the state back to the loaded seed, `period_o` takes the count and `period_done_o` is high for one cycle.
- R11: After reset, the state is 0x0000, `period_o` is 0 and `period_done_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| step_i | input | 1 | Advance the register one step |
| load_i | input | 1 | Load the seed and restart period measurement |
| seed_i | input | 16 | Seed value |
| tap_mask_i | input | 16 | Tap mask, bit i selects register bit i |
| xnor_mode_i | input | 1 | 0 = XOR feedback, 1 = XNOR feedback |
| mirror_i | input | 1 | Use the mirrored tap set |
| state_o | output | 16 | Current register state |
| bit_o | output | 1 | Serial output (state bit 0) |
| lockup_o | output | 1 | Register holds the lock-up state for the mode |
| period_o | output | 17 | Last measured period |
| period_done_o | output | 1 | One-cycle pulse when the period is latched |

## Verification
On every cycle, the assertions check the shift direction, load priority, hold when idle, persistence of the lock-up state, the mirror mapping keeping the tap count, and that the done pulse lasts one cycle and coincides with the seed state. Only the bench scenarios can show the actual feedback values: the 0xACE1 to 0x5670 transition, the XNOR walk out of zero, and the full 65535-step periods for the default and mirrored second tap sets, each compared step by step against an independent model.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  typedef enum logic {
    FB_XOR  = 1'b0,
    FB_XNOR = 1'b1
  } fb_mode_e;

  localparam int unsigned LFSR_W = 16;
endpackage

// File: rtl/lfsr_tap_map.sv
module lfsr_tap_map #(
  parameter int unsigned WIDTH = lfsr_pkg::LFSR_W
) (
  input  logic [WIDTH-1:0] mask_i,
  input  logic             mirror_i,
  output logic [WIDTH-1:0] mask_o
);
  logic [WIDTH-1:0] mirrored;

  // tap t sits at bit WIDTH-t; mirror t -> WIDTH-t keeps bit 0, swaps k <-> WIDTH-k
  assign mirrored[0] = mask_i[0];
  for (genvar k = 1; k < WIDTH; k++) begin : g_mir
    assign mirrored[k] = mask_i[WIDTH-k];
  end

  assign mask_o = mirror_i ? mirrored : mask_i;

  always_comb begin
    a_r8_tap_count : assert ($countones(mask_o) == $countones(mask_i));
  end
endmodule

// File: rtl/lfsr_feedback.sv
module lfsr_feedback #(
  parameter int unsigned WIDTH = lfsr_pkg::LFSR_W
) (
  input  logic [WIDTH-1:0] state_i,
  input  logic [WIDTH-1:0] mask_i,
  input  lfsr_pkg::fb_mode_e mode_i,
  output logic             fb_o,
  output logic [WIDTH-1:0] nxt_o
);
  logic parity;

  assign parity = ^(state_i & mask_i);
  assign fb_o   = (mode_i == lfsr_pkg::FB_XNOR) ? ~parity : parity;
  assign nxt_o  = {fb_o, state_i[WIDTH-1:1]};
endmodule

// File: rtl/lfsr_period.sv
module lfsr_period #(
  parameter int unsigned WIDTH = lfsr_pkg::LFSR_W,
  localparam int unsigned CNT_W = WIDTH + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             step_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic [WIDTH-1:0] nxt_i,
  input  logic [WIDTH-1:0] state_i,
  output logic [CNT_W-1:0] period_o,
  output logic             done_o
);
  logic [WIDTH-1:0] seed_q;
  logic [CNT_W-1:0] cnt_q, cnt_inc;
  logic             armed_q;

  assign cnt_inc = (&cnt_q) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seed_q   <= '0;
      cnt_q    <= '0;
      armed_q  <= 1'b0;
      period_o <= '0;
      done_o   <= 1'b0;
    end else if (load_i) begin
      seed_q  <= seed_i;
      cnt_q   <= '0;
      armed_q <= 1'b1;
      done_o  <= 1'b0;
    end else if (step_i) begin
      cnt_q <= cnt_inc;
      if (armed_q && nxt_i == seed_q) begin
        period_o <= cnt_inc;
        done_o   <= 1'b1;
        armed_q  <= 1'b0;
      end else begin
        done_o <= 1'b0;
      end
    end else begin
      done_o <= 1'b0;
    end
  end

  a_r10_done_pulse : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r10_done_at_seed : assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> state_i == seed_q);
endmodule

// File: rtl/lfsr_fib_gen.sv
module lfsr_fib_gen #(
  parameter int unsigned WIDTH = lfsr_pkg::LFSR_W,
  parameter logic [WIDTH-1:0] RESET_STATE = '0,
  localparam int unsigned CNT_W = WIDTH + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             load_i,
  input  logic [WIDTH-1:0] seed_i,
  input  logic [WIDTH-1:0] tap_mask_i,
  input  logic             xnor_mode_i,
  input  logic             mirror_i,
  output logic [WIDTH-1:0] state_o,
  output logic             bit_o,
  output logic             lockup_o,
  output logic [CNT_W-1:0] period_o,
  output logic             period_done_o
);
  import lfsr_pkg::*;

  fb_mode_e         mode;
  logic [WIDTH-1:0] eff_mask, nxt_state, state_q;
  logic             fb_bit;

  assign mode = xnor_mode_i ? FB_XNOR : FB_XOR;

  lfsr_tap_map #(.WIDTH(WIDTH)) u_map (
    .mask_i  (tap_mask_i),
    .mirror_i(mirror_i),
    .mask_o  (eff_mask)
  );

  lfsr_feedback #(.WIDTH(WIDTH)) u_fb (
    .state_i(state_q),
    .mask_i (eff_mask),
    .mode_i (mode),
    .fb_o   (fb_bit),
    .nxt_o  (nxt_state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      state_q <= RESET_STATE;
    else if (load_i)  state_q <= seed_i;
    else if (step_i)  state_q <= nxt_state;
  end

  lfsr_period #(.WIDTH(WIDTH)) u_per (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_i),
    .step_i  (step_i),
    .seed_i  (seed_i),
    .nxt_i   (nxt_state),
    .state_i (state_q),
    .period_o(period_o),
    .done_o  (period_done_o)
  );

  assign state_o  = state_q;
  assign bit_o    = state_q[0];
  assign lockup_o = (mode == FB_XNOR) ? (&state_q) : ~(|state_q);

  a_r1_shift : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> state_o[WIDTH-2:0] == $past(state_o[WIDTH-1:1]));
  a_r6_load_prio : assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> state_o == $past(seed_i));
  a_r7_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(state_o));
  a_r5_lock_sticks : assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i && lockup_o) |=> $stable(state_o));
endmodule

// File: tb/lfsr_fib_gen_tb.sv
module lfsr_fib_gen_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        step = 1'b0, load = 1'b0, xnor_m = 1'b0, mirror = 1'b0;
  logic [15:0] seed = '0, mask = 16'h002D;
  logic [15:0] state;
  logic        sbit, lockup, done;
  logic [16:0] period;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #4 clk = ~clk;

  lfsr_fib_gen u_dut (
    .clk_i(clk), .rst_ni(rst_n), .step_i(step), .load_i(load), .seed_i(seed),
    .tap_mask_i(mask), .xnor_mode_i(xnor_m), .mirror_i(mirror),
    .state_o(state), .bit_o(sbit), .lockup_o(lockup),
    .period_o(period), .period_done_o(done)
  );

  function automatic logic [15:0] mir(input logic [15:0] m);
    logic [15:0] r;
    r[0] = m[0];
    for (int k = 1; k < 16; k++) r[k] = m[16-k];
    return r;
  endfunction

  function automatic logic [15:0] model(input logic [15:0] s, input logic [15:0] m, input logic xn);
    logic f = 1'b0;
    for (int i = 0; i < 16; i++) if (m[i]) f = f ^ s[i];
    if (xn) f = ~f;
    return {f, s[15:1]};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic do_load(input logic [15:0] s);
    seed = s; load = 1'b1; step = 1'b0;
    @(negedge clk);
    load = 1'b0;
  endtask

  task automatic t_reset;
    chk(state == 16'h0000, "R11 state", state, 0);
    chk(period == 17'd0, "R11 period", period, 0);
    chk(done == 1'b0, "R11 done", done, 0);
  endtask

  task automatic t_known_step;
    xnor_m = 1'b0; mirror = 1'b0; mask = 16'h002D;
    do_load(16'hACE1);
    chk(state == 16'hACE1, "R6 load", state, 16'hACE1);
    chk(lockup == 1'b0, "R9 no lock", lockup, 0);
    step = 1'b1; @(negedge clk); step = 1'b0;
    chk(state == 16'h5670, "R2 ACE1->5670", state, 16'h5670);
    chk(sbit == state[0], "R1 bit_o", sbit, state[0]);
    @(negedge clk);
    chk(state == 16'h5670, "R7 hold", state, 16'h5670);
  endtask

  task automatic t_xnor_walk;
    logic [15:0] exp = 16'h0000;
    xnor_m = 1'b1; mask = 16'h002D;
    do_load(16'h0000);
    chk(lockup == 1'b0, "R9 xnor zero ok", lockup, 0);
    step = 1'b1;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      exp = model(exp, 16'h002D, 1'b1);
      chk(state == exp, "R4 xnor walk", state, exp);
      if (i == 0) chk(state == 16'h8000, "R4 zero->8000", state, 16'h8000);
    end
    step = 1'b0;
    do_load(16'hFFFF);
    chk(lockup == 1'b1, "R9 xnor ones lock", lockup, 1);
    step = 1'b1; repeat (3) @(negedge clk); step = 1'b0;
    chk(state == 16'hFFFF, "R4 ones stuck", state, 16'hFFFF);
    xnor_m = 1'b0; #1;
    chk(lockup == 1'b0, "R9 comb mode change", lockup, 0);
  endtask

  task automatic t_xor_lock;
    xnor_m = 1'b0;
    do_load(16'h0000);
    chk(lockup == 1'b1, "R9 xor zero lock", lockup, 1);
    step = 1'b1; repeat (4) @(negedge clk); step = 1'b0;
    chk(state == 16'h0000, "R5 zero stuck", state, 0);
  endtask

  task automatic t_load_prio;
    seed = 16'h1234; load = 1'b1; step = 1'b1;
    @(negedge clk);
    load = 1'b0; step = 1'b0;
    chk(state == 16'h1234, "R6 load over step", state, 16'h1234);
    mask = 16'h002D; mirror = 1'b1; xnor_m = 1'b0;
    step = 1'b1; @(negedge clk); step = 1'b0;
    chk(state == model(16'h1234, mir(16'h002D), 1'b0), "R8 mirror step", state,
        model(16'h1234, mir(16'h002D), 1'b0));
    mirror = 1'b0;
  endtask

  task automatic t_period(input logic [15:0] m, input logic mr, input logic [15:0] s, input string req);
    logic [15:0] exp = s;
    logic [15:0] em = mr ? mir(m) : m;
    int steps = 0;
    bit track_ok = 1'b1, zero_seen = 1'b0;
    mask = m; mirror = mr; xnor_m = 1'b0;
    do_load(s);
    step = 1'b1;
    while (steps < 70000) begin
      @(negedge clk);
      steps++;
      exp = model(exp, em, 1'b0);
      if (state != exp) track_ok = 1'b0;
      if (state == 16'h0000) zero_seen = 1'b1;
      if (done) break;
    end
    step = 1'b0;
    chk(track_ok, {req, " trajectory"}, state, exp);
    chk(!zero_seen, {req, " no zero"}, zero_seen, 0);
    chk(steps == 65535, {req, " steps"}, steps, 65535);
    chk(period == 17'd65535, "R10 period_o", period, 65535);
    chk(state == s, {req, " seed recurs"}, state, s);
    @(negedge clk);
    chk(done == 1'b0, "R10 done one cycle", done, 0);
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=1 exp=0");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_known_step;
    t_xnor_walk;
    t_xor_lock;
    t_load_prio;
    t_period(16'h002D, 1'b0, 16'hACE1, "R3");
    t_period(16'h100B, 1'b1, 16'h0001, "R8");
    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule